// File: doc/BRIEF.md
# Parcel Address and Issue Pipeline

This block is the front of an instruction issue path. It keeps the program address in units of 16-bit parcels. It asks an instruction fetch source for the parcel at that address. Each parcel it accepts moves through three stages:

- a next-parcel stage;
- a current-parcel stage, which holds the first parcel of an instruction;
- a lower-parcel stage, which holds the second parcel of a two-parcel instruction.

An instruction leaves the block through a registered issue port. A single-parcel instruction leaves alone. A two-parcel instruction leaves with both of its parcels together.

A branch that is taken, or a switch to a new context, loads a new program address on `load_en`. The same load discards every parcel already in the stages. The program address is an output at all times, so surrounding logic can save it when the context changes. A `stall` input holds the whole pipeline. Reset clears only the valid flags. The program address and the parcel data keep their values through reset.

Top module: `parcel_issue_pipe`

## Requirements
- R1: `fetch_addr` is 24 bits wide. Bits 23:2 are the word address and bits 1:0 select one of four parcels in that word. Counting past parcel 3 carries into the word field. Counting past 24'hFFFFFF wraps to 0.
- R2: `fetch_addr` increases by exactly one in each cycle where a parcel is accepted. It does not change in a cycle with `fetch_valid` low. While the stages keep flowing (no stall, no load, not in reset), every cycle with `fetch_valid` high accepts a parcel.
- R3: Outside reset, `load_en` puts `load_addr` into `fetch_addr` on the next edge. The load takes priority over both the increment and `stall`.
- R4: A load empties all three stages. `issue_valid` is low on the edge of the load. The first instruction issued after the load comes from the parcel at `load_addr`.
- R5: Instructions issue in program order. Bit 15 of the first parcel sets the length: 0 means one parcel, 1 means two. For a two-parcel instruction the first parcel comes from address a and the second from a+1, and `issue_two` is 1.
- R6: A two-parcel instruction issues only after its second parcel has been fetched. Gaps in `fetch_valid` delay instructions but never corrupt or reorder them.
- R7: While `stall` is high and no load is applied, nothing issues (`issue_valid` is 0), `fetch_addr` holds, and no parcel is accepted. When `stall` falls, the stream continues with no loss.
- R8: Reset drives `issue_valid` low and clears the valid flags of all stages. `fetch_addr` keeps its value through reset. After reset, issue restarts from the parcel at that held address.
- R9: With parcels supplied every cycle, the first instruction after a load is reported by `issue_valid` 3 edges after the load edge if it is a single-parcel instruction, and 4 edges after if it is a two-parcel instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (clears valid flags only) |
| fetch_valid | input | 1 | The fetch source has the parcel for `fetch_addr` ready |
| fetch_parcel | input | 16 | Parcel at `fetch_addr` |
| load_en | input | 1 | Branch-taken or context-switch load of the address |
| load_addr | input | 24 | New program address, in parcels |
| stall | input | 1 | Hold issue and the whole pipeline |
| fetch_addr | output | 24 | Program address of the parcel being requested |
| issue_valid | output | 1 | An instruction is issued this cycle |
| issue_two | output | 1 | The issued instruction has two parcels |
| issue_first | output | 16 | First parcel of the issued instruction |
| issue_second | output | 16 | Second parcel; meaningful only when `issue_two` is 1 |

## Verification
The bench uses the default parameters: 16-bit parcels, a 24-bit address and the length flag in bit 15. With these defaults, a load just below 24'hFFFFFF takes the address through the wrap to zero, and the parcel field carries into the word field on every fourth parcel. The fetch source is a hash of the address, so one-parcel and two-parcel instructions mix at every alignment. Three further cases are covered:

- gaps in `fetch_valid` that split a two-parcel instruction;
- a load applied while `stall` is high;
- back-to-back loads.

// File: rtl/pip_pkg.sv
package pip_pkg;
  // Where the next-parcel stage hands its contents in a given cycle
  typedef enum logic [1:0] {
    MV_NONE   = 2'd0,
    MV_TO_CUR = 2'd1,
    MV_TO_LOW = 2'd2
  } move_e;
endpackage

// File: rtl/pip_addr_reg.sv
module pip_addr_reg #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          adv,
  output logic [AW-1:0] pa
);
  localparam logic [AW-1:0] STEP = AW'(1);

  // Reset does not clear the address; it only blocks updates.
  always_ff @(posedge clk) begin
    if (!rst) begin
      if (load)     pa <= load_val;
      else if (adv) pa <= pa + STEP;
    end
  end
endmodule

// File: rtl/pip_stage_ctrl.sv
module pip_stage_ctrl
  import pip_pkg::*;
#(
  parameter int PW      = 16,
  parameter int LEN_BIT = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          hold,
  input  logic          fetch_valid,
  input  logic [PW-1:0] fetch_parcel,
  output logic          accept,
  output logic          fire,
  output logic          fire_two,
  output logic [PW-1:0] fire_first,
  output logic [PW-1:0] fire_second
);
  logic          nxt_v, cur_v, low_v;
  logic [PW-1:0] nxt_d, cur_d, low_d;
  logic          cur_two;
  logic          flowing;
  move_e         move;

  assign cur_two = cur_d[LEN_BIT];
  assign flowing = !hold && !flush && !rst;
  assign fire    = flowing && cur_v && (!cur_two || low_v);

  always_comb begin
    move = MV_NONE;
    if (flowing && nxt_v) begin
      if (cur_v && cur_two && !low_v) move = MV_TO_LOW;
      else if (!cur_v || fire)        move = MV_TO_CUR;
    end
  end

  assign accept = flowing && fetch_valid && (!nxt_v || (move != MV_NONE));

  // Parcel data: never reset
  always_ff @(posedge clk) begin
    if (accept)              nxt_d <= fetch_parcel;
    if (move == MV_TO_CUR)   cur_d <= nxt_d;
    if (move == MV_TO_LOW)   low_d <= nxt_d;
  end

  // Valid flags: cleared by reset and by a load
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      nxt_v <= 1'b0;
      cur_v <= 1'b0;
      low_v <= 1'b0;
    end else begin
      if (accept)                 nxt_v <= 1'b1;
      else if (move != MV_NONE)   nxt_v <= 1'b0;
      if (move == MV_TO_CUR)      cur_v <= 1'b1;
      else if (fire)              cur_v <= 1'b0;
      if (move == MV_TO_LOW)      low_v <= 1'b1;
      else if (fire)              low_v <= 1'b0;
    end
  end

  assign fire_two    = cur_two;
  assign fire_first  = cur_d;
  assign fire_second = low_d;

  // R6
  low_follows_cur_chk: assert property (@(posedge clk) disable iff (rst)
    low_v |-> cur_v);
endmodule

// File: rtl/pip_issue_reg.sv
module pip_issue_reg #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic          fire_two,
  input  logic [PW-1:0] fire_first,
  input  logic [PW-1:0] fire_second,
  output logic          iss_valid,
  output logic          iss_two,
  output logic [PW-1:0] iss_first,
  output logic [PW-1:0] iss_second
);
  always_ff @(posedge clk) begin
    if (rst) iss_valid <= 1'b0;
    else     iss_valid <= fire;
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      iss_two    <= fire_two;
      iss_first  <= fire_first;
      iss_second <= fire_second;
    end
  end
endmodule

// File: rtl/parcel_issue_pipe.sv
module parcel_issue_pipe #(
  parameter int PW      = 16,
  parameter int AW      = 24,
  parameter int LEN_BIT = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_valid,
  input  logic [PW-1:0] fetch_parcel,
  input  logic          load_en,
  input  logic [AW-1:0] load_addr,
  input  logic          stall,
  output logic [AW-1:0] fetch_addr,
  output logic          issue_valid,
  output logic          issue_two,
  output logic [PW-1:0] issue_first,
  output logic [PW-1:0] issue_second
);
  logic          accept, fire, fire_two;
  logic [PW-1:0] fire_first, fire_second;

  pip_addr_reg #(.AW(AW)) u_addr (
    .clk(clk), .rst(rst), .load(load_en), .load_val(load_addr),
    .adv(accept), .pa(fetch_addr)
  );

  pip_stage_ctrl #(.PW(PW), .LEN_BIT(LEN_BIT)) u_stages (
    .clk(clk), .rst(rst), .flush(load_en), .hold(stall),
    .fetch_valid(fetch_valid), .fetch_parcel(fetch_parcel),
    .accept(accept), .fire(fire), .fire_two(fire_two),
    .fire_first(fire_first), .fire_second(fire_second)
  );

  pip_issue_reg #(.PW(PW)) u_issue (
    .clk(clk), .rst(rst), .fire(fire), .fire_two(fire_two),
    .fire_first(fire_first), .fire_second(fire_second),
    .iss_valid(issue_valid), .iss_two(issue_two),
    .iss_first(issue_first), .iss_second(issue_second)
  );

  // R3
  load_takes_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> fetch_addr == $past(load_addr));

  // R4
  flush_no_issue_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> !issue_valid);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stall && !load_en) |=> ($stable(fetch_addr) && !issue_valid));

  // R2
  no_fetch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!fetch_valid && !load_en) |=> $stable(fetch_addr));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && !stall && !load_en) |=> fetch_addr == $past(fetch_addr) + AW'(1));
endmodule

// File: tb/parcel_issue_pipe_tb.sv
`timescale 1ns/1ps
module parcel_issue_pipe_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_valid = 1'b0;
  logic [15:0] fetch_parcel;
  logic        load_en = 1'b0;
  logic [23:0] load_addr = '0;
  logic        stall = 1'b0;
  logic [23:0] fetch_addr;
  logic        issue_valid, issue_two;
  logic [15:0] issue_first, issue_second;

  int checks = 0;
  int fails  = 0;
  logic [32:0] exp_q[$];
  logic [23:0] pexp;
  bit          track = 0;

  always #5 clk = ~clk;

  parcel_issue_pipe u_dut (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_parcel(fetch_parcel),
    .load_en(load_en), .load_addr(load_addr), .stall(stall),
    .fetch_addr(fetch_addr), .issue_valid(issue_valid), .issue_two(issue_two),
    .issue_first(issue_first), .issue_second(issue_second)
  );

  // Fetch source contents: a hash of the address
  function automatic logic [15:0] mem(input logic [23:0] a);
    logic [15:0] h;
    h = a[15:0] * 16'hA5B3;
    return h ^ {a[23:16], a[7:0]};
  endfunction

  assign fetch_parcel = mem(fetch_addr);

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Driver side of the scoreboard: expected issue stream from address a
  task automatic regen(input logic [23:0] a);
    logic [23:0] p;
    logic [15:0] w;
    exp_q.delete();
    p = a;
    for (int i = 0; i < 64; i++) begin
      w = mem(p);
      if (w[15]) begin
        exp_q.push_back({1'b1, w, mem(p + 24'd1)});
        p = p + 24'd2;
      end else begin
        exp_q.push_back({1'b0, w, 16'h0000});
        p = p + 24'd1;
      end
    end
  endtask

  // Monitor side: compare each issued instruction
  task automatic monitor();
    logic [32:0] e;
    if (issue_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R5 unexpected issue", {32'h0, issue_first}, 48'h0);
      end else begin
        e = exp_q.pop_front();
        chk(issue_two == e[32] && issue_first == e[31:16], "R5 order/first parcel",
            {31'h0, issue_two, issue_first}, {31'h0, e[32:16]});
        if (e[32])
          chk(issue_second == e[15:0], "R6 second parcel", {32'h0, issue_second}, {32'h0, e[15:0]});
      end
    end
  endtask

  task automatic step();
    bit adv;
    adv = fetch_valid && !stall && !load_en && !rst;
    @(posedge clk);
    #1;
    if (adv) pexp = pexp + 24'd1;
    monitor();
    if (track && !load_en)
      chk(fetch_addr == pexp, "R2 address count", {24'h0, fetch_addr}, {24'h0, pexp});
  endtask

  task automatic do_load(input logic [23:0] a);
    load_en = 1'b1;
    load_addr = a;
    step();
    load_en = 1'b0;
    chk(fetch_addr == a, "R3 load", {24'h0, fetch_addr}, {24'h0, a});
    chk(!issue_valid, "R4 no issue on load edge", {47'h0, issue_valid}, 48'h0);
    regen(a);
    pexp = a;
    track = 1;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [23:0] held;
    int lat;
    repeat (3) step();
    rst = 1'b0;
    step();
    chk(!issue_valid, "R8 reset state", {47'h0, issue_valid}, 48'h0);

    // R9 latency and R2 continuous flow
    fetch_valid = 1'b1;
    do_load(24'h000100);
    lat = mem(24'h000100)[15] ? 4 : 3;
    for (int n = 1; n <= lat; n++) begin
      step();
      chk(issue_valid == (n == lat), "R9 first-issue latency", {47'h0, issue_valid}, {47'h0, n == lat});
    end
    repeat (30) step();

    // R6 gaps in the fetch supply
    for (int i = 0; i < 40; i++) begin
      fetch_valid = (i % 3) != 0;
      step();
    end
    fetch_valid = 1'b1;

    // R7 stall
    stall = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step();
      chk(!issue_valid, "R7 no issue while stalled", {47'h0, issue_valid}, 48'h0);
    end
    stall = 1'b0;
    repeat (20) step();

    // R3 load during stall, R1 wrap of the address
    stall = 1'b1;
    step();
    do_load(24'hFFFFFD);
    step();
    chk(fetch_addr == 24'hFFFFFD, "R7 hold after load", {24'h0, fetch_addr}, 48'hFFFFFD);
    stall = 1'b0;
    repeat (4) step();
    chk(fetch_addr[23:2] == 22'h0 && fetch_addr[1:0] == 2'd1, "R1 wrap to word 0",
        {24'h0, fetch_addr}, 48'h1);
    repeat (20) step();

    // R1 carry from parcel field into word field
    do_load(24'h0012FE);
    repeat (2) step();
    chk(fetch_addr == 24'h001300, "R1 parcel carry", {24'h0, fetch_addr}, 48'h001300);
    repeat (20) step();

    // R4 back-to-back loads
    do_load(24'h004441);
    do_load(24'h0A0A02);
    repeat (25) step();

    // R8 reset mid-stream keeps the address
    held = fetch_addr;
    rst = 1'b1;
    step();
    chk(!issue_valid, "R8 reset clears issue", {47'h0, issue_valid}, 48'h0);
    step();
    rst = 1'b0;
    chk(fetch_addr == held, "R8 address kept through reset", {24'h0, fetch_addr}, {24'h0, held});
    regen(held);
    pexp = held;
    repeat (25) step();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule